// File: doc/BRIEF.md
# Predicated Operand Bypass Network

This block sits beside the register-read and execute stages of a machine with several parallel integer pipes. For every source operand in both stages it compares the operand's register tag with the destination tags of results that have been computed but not yet written back. When a usable match exists, it selects that result and reports which producer slot supplied it. Each producer carries a qualifying predicate. A producer whose predicate is false is skipped, and the search continues to older results.

The set of producer-to-consumer paths is fixed by a parameter. The options are each pipe to itself only, each pipe to itself and the next-higher pipe, each pipe to itself and both neighbours, or every pipe to every pipe. Pipe indices are linear and do not wrap. A read-stage operand whose correct value sits in a producer with no path to its pipe raises the stall request. That operand then waits in read until the value reaches the register file. Execute-stage operands never stall. They either take a reachable value or keep the value they carried from read.

The block is purely combinational from tags to selects and data. Clock and reset are used only by the embedded property checks. There is no data stream, so there is no valid/ready handshake.

Top module: `fwd_net_top`

## Requirements
- R1: A source operand whose tag equals the tag of a valid, predicate-true producer with a path to the operand's pipe gets select k+1 and that producer's 64-bit value. Producer slot k is stage*NPIPE+pipe, and stage 0 is the youngest.
- R2: A producer whose predicate is false is never selected. The next older qualifying producer, if any, decides the outcome instead.
- R3: Among qualifying producers the youngest wins. A lower stage index beats a higher one. Within one stage, the higher pipe index beats the lower one.
- R4: With the self-only topology, pipe p forwards only to pipe p.
- R5: With the pair topology, pipe p reaches pipes p and p+1. With the trio topology, it reaches p-1, p and p+1. With the full topology, it reaches every pipe. No path wraps between pipe 0 and pipe NPIPE-1.
- R6: The stall output is high exactly when some read-stage operand's winning producer has no path to that operand's pipe. This holds even if an older reachable producer also matches.
- R7: An execute-stage operand whose winning producer is unreachable gets select 0 and data 0, and it does not affect the stall output.
- R8: Source tag 0 never matches any producer. Its select is 0, its data is 0, and it never causes a stall.
- R9: An operand with no forwarded value gets select 0 and data 0.
- R10: A producer whose valid bit is low is ignored whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock sampling the embedded properties |
| rst_n | input | 1 | Active-low reset, disables the properties |
| rd_tag | input | NPIPE*NSRC*TAGW | Read-stage source tags, operand o = pipe*NSRC+slot |
| ex_tag | input | NPIPE*NSRC*TAGW | Execute-stage source tags, same layout |
| prod_vld | input | NPIPE*DEPTH | Producer valid bits, slot stage*NPIPE+pipe |
| prod_pred | input | NPIPE*DEPTH | Producer qualifying predicates |
| prod_tag | input | NPIPE*DEPTH*TAGW | Producer destination tags |
| prod_data | input | NPIPE*DEPTH*XLEN | Producer result values |
| rd_sel | output | NPIPE*NSRC*SELW | Read-stage selects, 0 = none, k+1 = slot k |
| rd_data | output | NPIPE*NSRC*XLEN | Read-stage forwarded values |
| ex_sel | output | NPIPE*NSRC*SELW | Execute-stage selects |
| ex_data | output | NPIPE*NSRC*XLEN | Execute-stage forwarded values |
| stall_rd | output | 1 | Unbypassable read-after-write hazard in read |

## Verification
A fault in the priority order or in the path mask shows up at once, in the same cycle, as a wrong select or wrong data on the operand concerned. A missing path that is treated as present gives a forwarded value where the stall should be high. An extra path that is treated as absent raises a stall that should not exist. Predicate and tag-zero faults appear as a select pointing at an unqualified slot. Because the block holds no state, no fault can hide for more than the cycle in which its inputs arise.

// File: rtl/fwd_net_pkg.sv
`timescale 1ns/1ps
package fwd_net_pkg;

  typedef enum logic [1:0] {
    FWD_SELF = 2'd0,
    FWD_PAIR = 2'd1,
    FWD_TRIO = 2'd2,
    FWD_ALL  = 2'd3
  } fwd_topo_e;

  // Path from producer pipe src to consumer pipe dst; linear, no wrap.
  function automatic logic path_ok(fwd_topo_e topo, int src, int dst);
    case (topo)
      FWD_SELF: return src == dst;
      FWD_PAIR: return (src == dst) || (src + 1 == dst);
      FWD_TRIO: return (src == dst) || (src + 1 == dst) || (dst + 1 == src);
      default:  return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/fwd_match.sv
`timescale 1ns/1ps
module fwd_match #(
  parameter int NPROD = 8,
  parameter int TAGW  = 7
) (
  input  logic [TAGW-1:0]       src_tag,
  input  logic [NPROD-1:0]      prod_vld,
  input  logic [NPROD-1:0]      prod_pred,
  input  logic [NPROD*TAGW-1:0] prod_tag,
  output logic [NPROD-1:0]      hit
);
  logic src_live;
  assign src_live = |src_tag;   // tag 0 is the hard-wired zero register

  for (genvar k = 0; k < NPROD; k++) begin : g_cmp
    assign hit[k] = src_live && prod_vld[k] && prod_pred[k]
                    && (prod_tag[k*TAGW +: TAGW] == src_tag);
  end
endmodule

// File: rtl/fwd_pick.sv
`timescale 1ns/1ps
module fwd_pick
  import fwd_net_pkg::*;
#(
  parameter int        NPIPE = 4,
  parameter int        DEPTH = 2,
  parameter int        XLEN  = 64,
  parameter fwd_topo_e TOPO  = FWD_ALL,
  parameter int        DST   = 0,
  localparam int NPROD = NPIPE * DEPTH,
  localparam int IDXW  = (NPROD > 1) ? $clog2(NPROD) : 1,
  localparam int SELW  = $clog2(NPROD + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPROD-1:0]      hit,
  input  logic [NPROD*XLEN-1:0] prod_data,
  output logic [SELW-1:0]       sel,
  output logic [XLEN-1:0]       data,
  output logic                  blocked
);
  logic [NPROD-1:0] reach_m;
  logic [NPROD-1:0] sel_oh;
  logic             found;
  logic [IDXW-1:0]  widx;
  logic [XLEN-1:0]  wdata;

  for (genvar k = 0; k < NPROD; k++) begin : g_mask
    assign reach_m[k] = path_ok(TOPO, k % NPIPE, DST);
    assign sel_oh[k]  = (sel == SELW'(k + 1));
  end

  // Oldest first, so the last hit written is the youngest.
  always_comb begin
    found = 1'b0;
    widx  = '0;
    wdata = '0;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      for (int p = 0; p < NPIPE; p++) begin
        if (hit[s*NPIPE + p]) begin
          found = 1'b1;
          widx  = IDXW'(s*NPIPE + p);
          wdata = prod_data[(s*NPIPE + p)*XLEN +: XLEN];
        end
      end
    end
  end

  always_comb begin
    blocked = found && !reach_m[widx];
    if (found && reach_m[widx]) begin
      sel  = SELW'(widx) + SELW'(1);
      data = wdata;
    end else begin
      sel  = '0;
      data = '0;
    end
  end

  // R1/R2: a nonzero select points at exactly one qualified match
  p_sel_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0) |-> ($countones(sel_oh & hit) == 1));
  // R9: no forward means zero data
  p_nofwd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (data == '0));
  // R6: a blocked operand carries no select
  p_block_nosel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (sel == '0) && (hit != '0));
endmodule

// File: rtl/fwd_net_top.sv
`timescale 1ns/1ps
module fwd_net_top
  import fwd_net_pkg::*;
#(
  parameter int        NPIPE = 4,
  parameter int        NSRC  = 2,
  parameter int        DEPTH = 2,
  parameter int        TAGW  = 7,
  parameter int        XLEN  = 64,
  parameter fwd_topo_e TOPO  = FWD_ALL,
  localparam int NPROD = NPIPE * DEPTH,
  localparam int NOPS  = NPIPE * NSRC,
  localparam int SELW  = $clog2(NPROD + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NOPS*TAGW-1:0]  rd_tag,
  input  logic [NOPS*TAGW-1:0]  ex_tag,
  input  logic [NPROD-1:0]      prod_vld,
  input  logic [NPROD-1:0]      prod_pred,
  input  logic [NPROD*TAGW-1:0] prod_tag,
  input  logic [NPROD*XLEN-1:0] prod_data,
  output logic [NOPS*SELW-1:0]  rd_sel,
  output logic [NOPS*XLEN-1:0]  rd_data,
  output logic [NOPS*SELW-1:0]  ex_sel,
  output logic [NOPS*XLEN-1:0]  ex_data,
  output logic                  stall_rd
);
  logic [NOPS-1:0] rd_blk;
  logic [NOPS-1:0] ex_blk;

  for (genvar o = 0; o < NOPS; o++) begin : g_op
    logic [NPROD-1:0] rd_hit;
    logic [NPROD-1:0] ex_hit;

    fwd_match #(.NPROD(NPROD), .TAGW(TAGW)) rd_match_i (
      .src_tag(rd_tag[o*TAGW +: TAGW]), .prod_vld(prod_vld),
      .prod_pred(prod_pred), .prod_tag(prod_tag), .hit(rd_hit));
    fwd_match #(.NPROD(NPROD), .TAGW(TAGW)) ex_match_i (
      .src_tag(ex_tag[o*TAGW +: TAGW]), .prod_vld(prod_vld),
      .prod_pred(prod_pred), .prod_tag(prod_tag), .hit(ex_hit));

    fwd_pick #(.NPIPE(NPIPE), .DEPTH(DEPTH), .XLEN(XLEN), .TOPO(TOPO),
               .DST(o / NSRC)) rd_pick_i (
      .clk(clk), .rst_n(rst_n), .hit(rd_hit), .prod_data(prod_data),
      .sel(rd_sel[o*SELW +: SELW]), .data(rd_data[o*XLEN +: XLEN]),
      .blocked(rd_blk[o]));
    fwd_pick #(.NPIPE(NPIPE), .DEPTH(DEPTH), .XLEN(XLEN), .TOPO(TOPO),
               .DST(o / NSRC)) ex_pick_i (
      .clk(clk), .rst_n(rst_n), .hit(ex_hit), .prod_data(prod_data),
      .sel(ex_sel[o*SELW +: SELW]), .data(ex_data[o*XLEN +: XLEN]),
      .blocked(ex_blk[o]));

    // R8: register 0 never forwards
    p_zero_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_tag[o*TAGW +: TAGW] == '0) |->
        (rd_sel[o*SELW +: SELW] == '0) && !rd_blk[o]);
    // R7: an unreachable execute-stage winner leaves the operand unforwarded
    p_ex_nofwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ex_blk[o] |-> (ex_sel[o*SELW +: SELW] == '0)
                    && (ex_data[o*XLEN +: XLEN] == '0));
  end

  assign stall_rd = |rd_blk;

  // R6: a stall needs at least one live read-stage source and one producer
  p_stall_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_rd |-> (rd_tag != '0) && ((prod_vld & prod_pred) != '0));
endmodule

// File: tb/fwd_net_top_tb_top.sv
`timescale 1ns/1ps
module fwd_net_top_tb_top;
  import fwd_net_pkg::*;

  localparam int NPIPE = 4;
  localparam int NSRC  = 2;
  localparam int DEPTH = 2;
  localparam int TAGW  = 7;
  localparam int XLEN  = 64;
  localparam int NPROD = NPIPE * DEPTH;
  localparam int NOPS  = NPIPE * NSRC;
  localparam int SELW  = $clog2(NPROD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  bit              b_vld  [NPROD];
  bit              b_pred [NPROD];
  logic [TAGW-1:0] b_ptag [NPROD];
  logic [XLEN-1:0] b_pdat [NPROD];
  logic [TAGW-1:0] b_rtag [NOPS];
  logic [TAGW-1:0] b_etag [NOPS];

  logic [NOPS*TAGW-1:0]  rd_tag, ex_tag;
  logic [NPROD-1:0]      prod_vld, prod_pred;
  logic [NPROD*TAGW-1:0] prod_tag;
  logic [NPROD*XLEN-1:0] prod_data;

  always_comb begin
    for (int k = 0; k < NPROD; k++) begin
      prod_vld[k]                = b_vld[k];
      prod_pred[k]               = b_pred[k];
      prod_tag[k*TAGW +: TAGW]   = b_ptag[k];
      prod_data[k*XLEN +: XLEN]  = b_pdat[k];
    end
    for (int o = 0; o < NOPS; o++) begin
      rd_tag[o*TAGW +: TAGW] = b_rtag[o];
      ex_tag[o*TAGW +: TAGW] = b_etag[o];
    end
  end

  logic [NOPS*SELW-1:0] rd_sel_o  [4];
  logic [NOPS*XLEN-1:0] rd_data_o [4];
  logic [NOPS*SELW-1:0] ex_sel_o  [4];
  logic [NOPS*XLEN-1:0] ex_data_o [4];
  logic                 stall_o   [4];

  for (genvar t = 0; t < 4; t++) begin : g_dut
    fwd_net_top #(.NPIPE(NPIPE), .NSRC(NSRC), .DEPTH(DEPTH), .TAGW(TAGW),
                  .XLEN(XLEN), .TOPO(fwd_topo_e'(t))) dut_i (
      .clk(clk), .rst_n(rst_n), .rd_tag(rd_tag), .ex_tag(ex_tag),
      .prod_vld(prod_vld), .prod_pred(prod_pred), .prod_tag(prod_tag),
      .prod_data(prod_data), .rd_sel(rd_sel_o[t]), .rd_data(rd_data_o[t]),
      .ex_sel(ex_sel_o[t]), .ex_data(ex_data_o[t]), .stall_rd(stall_o[t]));
  end

  int n_chk  = 0;
  int n_fail = 0;

  // Requirement model: t 0 self, 1 next-higher, 2 both neighbours, 3 all
  function automatic bit m_reach(int t, int p, int c);
    case (t)
      0: return p == c;
      1: return (p == c) || (p + 1 == c);
      2: return (p == c) || (p == c + 1) || (p + 1 == c);
      default: return 1'b1;
    endcase
  endfunction

  function automatic int m_pick(int t, int c, logic [TAGW-1:0] tag, output bit blk);
    blk = 1'b0;
    if (tag == '0) return 0;
    for (int s = 0; s < DEPTH; s++)
      for (int p = NPIPE - 1; p >= 0; p--) begin
        int k = s * NPIPE + p;
        if (b_vld[k] && b_pred[k] && b_ptag[k] == tag) begin
          if (m_reach(t, p, c)) return k + 1;
          blk = 1'b1;
          return 0;
        end
      end
    return 0;
  endfunction

  task automatic check_all(string req);
    for (int t = 0; t < 4; t++) begin
      bit    bad = 1'b0;
      bit    exp_stall = 1'b0;
      string msg = "";
      string lbl = (req != "") ? req : (t == 3 ? "R1" : (t == 0 ? "R4" : "R5"));
      for (int o = 0; o < NOPS; o++) begin
        bit blk_r, blk_e;
        int es_r = m_pick(t, o / NSRC, b_rtag[o], blk_r);
        int es_e = m_pick(t, o / NSRC, b_etag[o], blk_e);
        logic [XLEN-1:0] ed_r = (es_r != 0) ? b_pdat[es_r-1] : '0;
        logic [XLEN-1:0] ed_e = (es_e != 0) ? b_pdat[es_e-1] : '0;
        int as_r = int'(rd_sel_o[t][o*SELW +: SELW]);
        int as_e = int'(ex_sel_o[t][o*SELW +: SELW]);
        exp_stall |= blk_r;
        if (!bad && (as_r != es_r || rd_data_o[t][o*XLEN +: XLEN] != ed_r)) begin
          bad = 1'b1;
          msg = $sformatf("rd op%0d sel=%0d data=%h expected sel=%0d data=%h",
                          o, as_r, rd_data_o[t][o*XLEN +: XLEN], es_r, ed_r);
        end
        if (!bad && (as_e != es_e || ex_data_o[t][o*XLEN +: XLEN] != ed_e)) begin
          bad = 1'b1;
          msg = $sformatf("ex op%0d sel=%0d data=%h expected sel=%0d data=%h",
                          o, as_e, ex_data_o[t][o*XLEN +: XLEN], es_e, ed_e);
        end
      end
      if (!bad && stall_o[t] != exp_stall) begin
        bad = 1'b1;
        msg = $sformatf("stall=%0b expected %0b", stall_o[t], exp_stall);
      end
      n_chk++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s topo=%0d %s", lbl, t, msg);
      end
    end
  endtask

  task automatic clear_all();
    for (int k = 0; k < NPROD; k++) begin
      b_vld[k] = 0; b_pred[k] = 0; b_ptag[k] = '0; b_pdat[k] = '0;
    end
    for (int o = 0; o < NOPS; o++) begin b_rtag[o] = '0; b_etag[o] = '0; end
  endtask

  task automatic put(int s, int p, int tag, bit pred, logic [XLEN-1:0] d);
    int k = s * NPIPE + p;
    b_vld[k] = 1; b_pred[k] = pred; b_ptag[k] = TAGW'(tag); b_pdat[k] = d;
  endtask

  task automatic apply(string req);
    @(negedge clk);
    #1;
    check_all(req);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_all();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    apply("R9");                                   // reset/idle: nothing forwards
    for (int o = 0; o < NOPS; o++) b_rtag[o] = 7'd5;
    apply("R9");                                   // live tags, no producers
    clear_all(); put(0, 0, 0, 1, 64'hAAAA); apply("R8");
    clear_all(); put(0, 0, 3, 0, 64'h1111); put(1, 0, 3, 1, 64'h2222);
    b_rtag[0] = 3; b_etag[0] = 3; apply("R2");     // predicate-false younger skipped
    clear_all(); put(0, 1, 4, 1, 64'h10); put(1, 1, 4, 1, 64'h20); put(0, 2, 4, 1, 64'h30);
    b_rtag[2] = 4; b_rtag[4] = 4; b_etag[5] = 4; apply("R3");
    clear_all(); put(0, 3, 6, 1, 64'hF00D);
    b_rtag[0] = 6; apply("R6");
    b_rtag[0] = 0; b_etag[1] = 6; apply("R7");
    clear_all(); put(0, 1, 2, 1, 64'hBEEF);
    b_rtag[4] = 2; b_rtag[1] = 2; apply("R5");
    apply("R4");
    clear_all(); put(0, 3, 5, 1, 64'h55); put(1, 0, 5, 1, 64'h66);
    b_rtag[0] = 5; apply("R6");                    // younger unreachable wins
    clear_all(); b_ptag[3] = 7; b_pred[3] = 1; b_pdat[3] = 64'h77;
    b_rtag[6] = 7; b_etag[6] = 7; apply("R10");
    clear_all(); put(1, 2, 1, 1, 64'hCAFE); b_etag[4] = 1; apply("R1");

    for (int n = 0; n < 1500; n++) begin
      for (int k = 0; k < NPROD; k++) begin
        b_vld[k]  = ($urandom_range(3) != 0);
        b_pred[k] = ($urandom_range(3) != 0);
        b_ptag[k] = TAGW'($urandom_range(7));
        b_pdat[k] = {$urandom, $urandom};
      end
      for (int o = 0; o < NOPS; o++) begin
        b_rtag[o] = TAGW'($urandom_range(7));
        b_etag[o] = TAGW'($urandom_range(7));
      end
      apply("");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule